// File: doc/BRIEF.md
# PCIe Fundamental Reset Sequencer

This block sits on the root-port side of a PCIe link. It drives the active-low fundamental reset line to the endpoint, the enable of the endpoint's reference clock, and a link-usable flag. It takes a power-good indication, a shutdown request and a software reset request. One state machine runs the sequence, and one shared down-counter times every interval. The counter is reloaded with the new state's interval on each state change. Every interval is a parameter given in system-clock cycles.

On power-up the sequencer first waits out the rail-settling interval with the clock off. It then enables the reference clock and waits out the clock-settling interval. Only then does it release reset, and it waits a post-release interval before it flags the link as usable. For a software reset it pulls reset low with the clock running, holds it for a short interval, and then repeats the release and post-release steps. For a shutdown it pulls reset low and keeps the clock running for a long hold interval. It then turns the clock off and gives a one-cycle completion pulse. The reference clock is never switched off before reset has been asserted.

When the endpoint is flagged as internal, the reset line is never released or toggled. The link is flagged usable as soon as power is good. Losing power-good in any state forces reset and the link flag low in the same cycle. The clock goes off on the next edge and the sequence starts over.

Top module: `pcie_rst_seq`

## Requirements
- R1: After reset, and while power-good has not been seen, the reset line is low (0), the clock enable, the ready flag and the done pulse are 0.
- R2: The clock enable rises exactly RAIL_CYC+1 cycles after the cycle in which power-good is first sampled high, with the reset line still low.
- R3: The reset line goes high exactly CLK_CYC cycles after the clock enable rises, and never while the clock enable was low in the previous cycle.
- R4: The ready flag rises exactly POST_CYC cycles after the reset line goes high, and is high only while the clock enable is high.
- R5: A software reset request seen while ready pulls the reset line low on the next edge with the clock kept on. The line is released SWRST_CYC cycles later, and ready returns POST_CYC cycles after that.
- R6: A shutdown request seen while ready pulls the reset line low and clears ready on the next edge with the clock kept on. The clock enable drops HOLD_CYC cycles later, with the done pulse high for exactly that one cycle. The block stays off while the request is held. Once the request is dropped, the block restarts, and the clock enable rises RAIL_CYC+2 cycles after the drop.
- R7: The clock enable never falls unless the reset line was already low in the previous cycle.
- R8: A loss of power-good drives the reset line and ready low in the same cycle, and the clock enable low on the next edge.
- R9: A shutdown request during the power-up sequence aborts it: one edge later the clock enable is high and the reset line low, and the R6 hold and off steps follow.
- R10: With the internal-endpoint strap set, the reset line stays low. Ready and the clock enable rise one edge after power-good is seen, software reset requests have no effect, and a shutdown request turns the clock off with a done pulse on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good_i | input | 1 | Power rails reported good |
| shdn_req_i | input | 1 | Shutdown or reboot request (level) |
| sw_rst_i | input | 1 | Software reset request, acted on while ready |
| ep_internal_i | input | 1 | Strap: endpoint is internal, reset line not managed |
| perst_n_o | output | 1 | Fundamental reset to the endpoint, active low |
| refclk_en_o | output | 1 | Reference clock enable |
| link_ready_o | output | 1 | Link may be used |
| shdn_done_o | output | 1 | One-cycle pulse when the clock is finally turned off |

## Verification
The scoreboard records every change of the power-good, shutdown and output pins, with the cycle distance since the previous change. It therefore catches an off-by-one in any interval: a counter reloaded with the full count instead of one less, or a state that skips its timer, shows up as a wrong gap. It aborts a shutdown in the middle of power-up, where a design that ignores the request would go on to release reset. It drops power-good while running, where a registered-only reset output would lag one cycle. It watches every fall of the clock enable, where a design that drops clock and reset together would violate the ordering. It runs the internal-endpoint strap with a software reset pulse, where a design that honours the pulse would produce an unexpected change.

// File: rtl/pcie_rst_seq_pkg.sv
// Shared types for the fundamental reset sequencer.
// Assumes: one state encoding, used by the FSM and by the output decode.
package pcie_rst_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,  // waiting for power-good
        ST_RAIL    = 3'd1,  // rails settling, clock off
        ST_CLKON   = 3'd2,  // clock running, settling before release
        ST_RELEASE = 3'd3,  // reset released, post-release wait
        ST_RUN     = 3'd4,  // operational
        ST_SWHOLD  = 3'd5,  // software reset, line held low
        ST_SDHOLD  = 3'd6,  // shutdown, line low with clock kept on
        ST_OFF     = 3'd7   // clock stopped, waiting for request to drop
    } seq_st_e;

    // States in which the reference clock must run.
    function automatic logic st_runs_refclk(seq_st_e s);
        return (s == ST_CLKON) || (s == ST_RELEASE) || (s == ST_RUN) ||
               (s == ST_SWHOLD) || (s == ST_SDHOLD);
    endfunction

    // States in which the reset line is released.
    function automatic logic st_releases_perst(seq_st_e s);
        return (s == ST_RELEASE) || (s == ST_RUN);
    endfunction

    // States whose exit is decided by the shared timer.
    function automatic logic st_is_timed(seq_st_e s);
        return (s == ST_RAIL) || (s == ST_CLKON) || (s == ST_RELEASE) ||
               (s == ST_SWHOLD) || (s == ST_SDHOLD);
    endfunction

endpackage

// File: rtl/pcie_rst_seq_timer.sv
// Shared interval timer.
// Loads a start value on request and counts down to zero, then holds.
// Assumes: the caller loads (interval - 1) on entry, so that a state whose
// exit waits for 'expired' lasts exactly 'interval' cycles.
module pcie_rst_seq_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    // Reload on request, else count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Expiry flag seen by the state machine.
    always_comb begin
        expired = (cnt_q == '0);
    end

    // R2
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

    // R3
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/pcie_rst_seq_fsm.sv
// Sequencing state machine.
// Picks the next state from power-good, the requests, the strap and the
// shared timer, and gives the timer the interval of any state it enters.
// Assumes: ep_internal_i is a static strap; every *_CYC is at least 1.
module pcie_rst_seq_fsm
    import pcie_rst_seq_pkg::*;
#(
    parameter int unsigned RAIL_CYC  = 5_000_000,
    parameter int unsigned CLK_CYC   = 5_000,
    parameter int unsigned POST_CYC  = 5_000_000,
    parameter int unsigned SWRST_CYC = 12_500,
    parameter int unsigned HOLD_CYC  = 25_000_000,
    parameter int unsigned CW        = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_good_i,
    input  logic          shdn_req_i,
    input  logic          sw_rst_i,
    input  logic          ep_internal_i,
    input  logic          tmr_expired,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output seq_st_e       st_q,
    output seq_st_e       st_d
);

    // Start value for the timer on entering a state.
    function automatic logic [CW-1:0] entry_count(seq_st_e s);
        unique case (s)
            ST_RAIL:    return CW'(RAIL_CYC - 1);
            ST_CLKON:   return CW'(CLK_CYC - 1);
            ST_RELEASE: return CW'(POST_CYC - 1);
            ST_SWHOLD:  return CW'(SWRST_CYC - 1);
            ST_SDHOLD:  return CW'(HOLD_CYC - 1);
            default:    return '0;
        endcase
    endfunction

    logic timed_done;

    // Timer expiry counts only in states the timer governs.
    always_comb begin
        timed_done = st_is_timed(st_q) && tmr_expired;
    end

    // Next-state choice: power loss, then shutdown, then software reset, then timer.
    always_comb begin
        st_d = st_q;
        if (!pwr_good_i) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (!shdn_req_i) begin
                        st_d = ep_internal_i ? ST_RUN : ST_RAIL;
                    end
                end
                ST_RAIL: begin
                    if (shdn_req_i)      st_d = ST_SDHOLD;
                    else if (timed_done) st_d = ST_CLKON;
                end
                ST_CLKON: begin
                    if (shdn_req_i)      st_d = ST_SDHOLD;
                    else if (timed_done) st_d = ST_RELEASE;
                end
                ST_RELEASE: begin
                    if (shdn_req_i)      st_d = ST_SDHOLD;
                    else if (timed_done) st_d = ST_RUN;
                end
                ST_RUN: begin
                    if (shdn_req_i) begin
                        st_d = ep_internal_i ? ST_OFF : ST_SDHOLD;
                    end else if (sw_rst_i && !ep_internal_i) begin
                        st_d = ST_SWHOLD;
                    end
                end
                ST_SWHOLD: begin
                    if (shdn_req_i)      st_d = ST_SDHOLD;
                    else if (timed_done) st_d = ST_RELEASE;
                end
                ST_SDHOLD: begin
                    if (timed_done)      st_d = ST_OFF;
                end
                ST_OFF: begin
                    if (!shdn_req_i)     st_d = ST_IDLE;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // Timer reload request on every state change.
    always_comb begin
        tmr_load = (st_d != st_q);
        tmr_val  = entry_count(st_d);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // R9
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good_i && shdn_req_i &&
         ((st_q == ST_RAIL) || (st_q == ST_CLKON) || (st_q == ST_RELEASE)))
        |=> (st_q == ST_SDHOLD));

    // R5
    swrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good_i && !shdn_req_i && sw_rst_i && !ep_internal_i &&
         (st_q == ST_RUN)) |=> (st_q == ST_SWHOLD));

    // R8
    pwr_loss_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good_i |=> (st_q == ST_IDLE));

endmodule

// File: rtl/pcie_rst_seq_drv.sv
// Output register stage.
// Decodes the next state into registered reset-line, clock-enable, ready
// and done values, so that each output changes on the edge that enters
// the state it belongs to.
// Assumes: st_q and st_d come from the same state machine.
module pcie_rst_seq_drv
    import pcie_rst_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  seq_st_e st_q,
    input  seq_st_e st_d,
    input  logic    ep_internal_i,
    output logic    perst_rel_q,
    output logic    refclk_q,
    output logic    ready_q,
    output logic    done_q
);

    // Register the decoded outputs of the state being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perst_rel_q <= 1'b0;
            refclk_q    <= 1'b0;
            ready_q     <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            perst_rel_q <= st_releases_perst(st_d) && !ep_internal_i;
            refclk_q    <= st_runs_refclk(st_d);
            ready_q     <= (st_d == ST_RUN);
            done_q      <= (st_d == ST_OFF) && (st_q != ST_OFF);
        end
    end

endmodule

// File: rtl/pcie_rst_seq.sv
// Top of the fundamental reset sequencer.
// Ties the state machine, the shared timer and the output register, and
// gates the reset line and ready with power-good so a power loss acts in
// the same cycle.
// Assumes: power-good is synchronous to clk; the strap changes only in reset.
module pcie_rst_seq
    import pcie_rst_seq_pkg::*;
#(
    parameter int unsigned RAIL_CYC  = 5_000_000,
    parameter int unsigned CLK_CYC   = 5_000,
    parameter int unsigned POST_CYC  = 5_000_000,
    parameter int unsigned SWRST_CYC = 12_500,
    parameter int unsigned HOLD_CYC  = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good_i,
    input  logic shdn_req_i,
    input  logic sw_rst_i,
    input  logic ep_internal_i,
    output logic perst_n_o,
    output logic refclk_en_o,
    output logic link_ready_o,
    output logic shdn_done_o
);

    localparam int unsigned MAX_A = (RAIL_CYC > CLK_CYC) ? RAIL_CYC : CLK_CYC;
    localparam int unsigned MAX_B = (POST_CYC > SWRST_CYC) ? POST_CYC : SWRST_CYC;
    localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned MAX_CYC = (MAX_C > HOLD_CYC) ? MAX_C : HOLD_CYC;
    localparam int unsigned CW = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expired;
    seq_st_e       st_q;
    seq_st_e       st_d;
    logic          perst_rel_q;
    logic          refclk_q;
    logic          ready_q;
    logic          done_q;

    pcie_rst_seq_fsm #(
        .RAIL_CYC  (RAIL_CYC),
        .CLK_CYC   (CLK_CYC),
        .POST_CYC  (POST_CYC),
        .SWRST_CYC (SWRST_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .CW        (CW)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwr_good_i    (pwr_good_i),
        .shdn_req_i    (shdn_req_i),
        .sw_rst_i      (sw_rst_i),
        .ep_internal_i (ep_internal_i),
        .tmr_expired   (tmr_expired),
        .tmr_load      (tmr_load),
        .tmr_val       (tmr_val),
        .st_q          (st_q),
        .st_d          (st_d)
    );

    pcie_rst_seq_timer #(
        .CW (CW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    pcie_rst_seq_drv u_drv (
        .clk           (clk),
        .rst_n         (rst_n),
        .st_q          (st_q),
        .st_d          (st_d),
        .ep_internal_i (ep_internal_i),
        .perst_rel_q   (perst_rel_q),
        .refclk_q      (refclk_q),
        .ready_q       (ready_q),
        .done_q        (done_q)
    );

    // Port drive: reset line and ready drop with power-good in the same cycle.
    always_comb begin
        perst_n_o    = perst_rel_q & pwr_good_i;
        link_ready_o = ready_q & pwr_good_i;
        refclk_en_o  = refclk_q;
        shdn_done_o  = done_q;
    end

    // R7
    clk_after_perst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(refclk_en_o) |-> !$past(perst_n_o));

    // R3
    clk_before_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perst_n_o) |-> $past(refclk_en_o));

    // R4
    ready_needs_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_ready_o |-> refclk_en_o);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_done_o |=> !shdn_done_o);

    // R6
    done_clk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_done_o |-> !refclk_en_o);

    // R8
    pwr_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good_i |=> (!refclk_en_o && !link_ready_o && !perst_n_o));

    // R10
    internal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ep_internal_i |-> !perst_n_o);

endmodule

// File: tb/pcie_rst_seq_bench.sv
// Scoreboard bench: driver tasks queue the expected pin changes and their
// cycle gaps; a monitor at the falling edge pops and compares each change.
module pcie_rst_seq_bench;

    localparam int unsigned T_RAIL  = 40;
    localparam int unsigned T_CLK   = 10;
    localparam int unsigned T_POST  = 30;
    localparam int unsigned T_SWRST = 12;
    localparam int unsigned T_HOLD  = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pg = 1'b0;
    logic sd = 1'b0;
    logic sw = 1'b0;
    logic internal = 1'b0;
    logic perst_n, refclk_en, ready, done;

    always #10 clk = ~clk;  // 50 MHz

    pcie_rst_seq #(
        .RAIL_CYC  (T_RAIL),
        .CLK_CYC   (T_CLK),
        .POST_CYC  (T_POST),
        .SWRST_CYC (T_SWRST),
        .HOLD_CYC  (T_HOLD)
    ) u_pcie_rst_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwr_good_i    (pg),
        .shdn_req_i    (sd),
        .sw_rst_i      (sw),
        .ep_internal_i (internal),
        .perst_n_o     (perst_n),
        .refclk_en_o   (refclk_en),
        .link_ready_o  (ready),
        .shdn_done_o   (done)
    );

    // Observed vector: {pg, sd, perst_n, refclk, ready, done}
    logic [5:0] obs;
    assign obs = {pg, sd, perst_n, refclk_en, ready, done};

    logic [5:0] q_vec[$];
    int         q_gap[$];
    string      q_tag[$];

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    task automatic expect_ev(input logic [5:0] v, input int gap, input string tag);
        q_vec.push_back(v);
        q_gap.push_back(gap);
        q_tag.push_back(tag);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic drain();
        while (q_vec.size() != 0) @(posedge clk);
        #5;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    // Monitor: detect each change, check ordering, compare against the queue.
    initial begin
        int cyc = 0;
        int last_cyc = 0;
        logic [5:0] prev = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst_n) begin
                prev = obs;
                last_cyc = cyc;
            end else if (obs !== prev) begin
                int gap;
                gap = cyc - last_cyc;
                if (prev[2] && !obs[2]) begin
                    n_checks++;
                    if (prev[3]) begin
                        n_fails++;
                        $display("FAIL R7 clock off while line released: prev=%b now=%b exp line low first",
                                 prev, obs);
                    end
                end
                n_checks++;
                if (q_vec.size() == 0) begin
                    n_fails++;
                    $display("FAIL unexpected change (R5/R10 no-effect): act=%b gap=%0d exp=no change",
                             obs, gap);
                end else begin
                    logic [5:0] ev;
                    int eg;
                    string tg;
                    ev = q_vec.pop_front();
                    eg = q_gap.pop_front();
                    tg = q_tag.pop_front();
                    if (obs !== ev || (eg != 0 && gap != eg)) begin
                        n_fails++;
                        $display("FAIL %s: act=%b gap=%0d exp=%b gap=%0d", tg, obs, gap, ev, eg);
                    end
                end
                prev = obs;
                last_cyc = cyc;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: act=hung exp=finished");
        summary();
    end

    // Driver: scenarios with external and internal endpoint.
    initial begin
        cycles(4);
        rst_n = 1'b1;
        cycles(10);
        // R1: quiet before power-good
        n_checks++;
        if (obs !== 6'b000000) begin
            n_fails++;
            $display("FAIL R1 reset state: act=%b exp=%b", obs, 6'b000000);
        end

        // R2 R3 R4: power-up
        expect_ev(6'b100000, 0, "R2 pg seen");
        expect_ev(6'b100100, T_RAIL + 1, "R2 clock on after rails");
        expect_ev(6'b101100, T_CLK, "R3 release after clock");
        expect_ev(6'b101110, T_POST, "R4 ready after release");
        pg = 1'b1;
        drain();
        cycles(5);

        // R5: software reset
        expect_ev(6'b100100, 0, "R5 line low clock on");
        expect_ev(6'b101100, T_SWRST, "R5 release after hold");
        expect_ev(6'b101110, T_POST, "R5 ready again");
        sw = 1'b1;
        cycles(1);
        sw = 1'b0;
        drain();
        cycles(5);

        // R6: shutdown from operation
        expect_ev(6'b111110, 0, "R6 request seen");
        expect_ev(6'b110100, 1, "R6 line low clock kept");
        expect_ev(6'b110001, T_HOLD, "R6 clock off with done");
        expect_ev(6'b110000, 1, "R6 done single cycle");
        sd = 1'b1;
        drain();
        cycles(20);
        expect_ev(6'b100000, 0, "R6 request dropped");
        expect_ev(6'b100100, T_RAIL + 2, "R6 restart clock on");
        expect_ev(6'b101100, T_CLK, "R3 release after restart");
        expect_ev(6'b101110, T_POST, "R4 ready after restart");
        sd = 1'b0;
        drain();
        cycles(5);

        // R8: power loss while running
        expect_ev(6'b000100, 0, "R8 line and ready drop at once");
        expect_ev(6'b000000, 1, "R8 clock off next edge");
        pg = 1'b0;
        drain();
        cycles(5);

        // R9: shutdown during rail wait
        expect_ev(6'b100000, 0, "R9 pg seen");
        expect_ev(6'b110000, 5, "R9 request in rail wait");
        expect_ev(6'b110100, 1, "R9 abort to hold");
        expect_ev(6'b110001, T_HOLD, "R9 clock off with done");
        expect_ev(6'b110000, 1, "R9 done single cycle");
        pg = 1'b1;
        cycles(5);
        sd = 1'b1;
        drain();
        cycles(5);
        expect_ev(6'b000000, 0, "R8 power and request dropped");
        pg = 1'b0;
        sd = 1'b0;
        drain();
        cycles(5);

        // R10: internal endpoint
        rst_n = 1'b0;
        internal = 1'b1;
        cycles(4);
        rst_n = 1'b1;
        cycles(5);
        expect_ev(6'b100000, 0, "R10 pg seen");
        expect_ev(6'b100110, 1, "R10 ready at once, line low");
        pg = 1'b1;
        drain();
        cycles(5);
        sw = 1'b1;
        cycles(1);
        sw = 1'b0;
        cycles(30);
        expect_ev(6'b110110, 0, "R10 request seen");
        expect_ev(6'b110001, 1, "R10 clock off with done");
        expect_ev(6'b110000, 1, "R10 done single cycle");
        sd = 1'b1;
        drain();
        cycles(5);
        expect_ev(6'b000000, 0, "R10 power and request dropped");
        pg = 1'b0;
        sd = 1'b0;
        drain();
        cycles(10);

        n_checks++;
        if (q_vec.size() != 0) begin
            n_fails++;
            $display("FAIL R1 leftover expectations: act=%0d exp=0", q_vec.size());
        end
        summary();
    end

endmodule